// File: doc/BRIEF.md
# Quad DAC Power-Down and Reference Controller

This block is the digital control core of a four-channel DAC. It takes an already-decoded 24-bit command word with a one-cycle strobe. The word holds a 4-bit command, a 4-bit channel address and 16 bits of data. The strobe marks the rising edge of the chip-select/load line. The block also takes the current chip-select level and an active-low, asynchronous load input.

From these inputs it keeps, for each channel, an input register, a DAC register and a power flag. It also keeps the internal reference state, the reference-source select and the bias enable. A power-up settling timer drives a busy flag.

The internal reference remembers which command switched it off, and that decides what can switch it back on. The load input powers up all channels whenever it falls. When chip-select is high, the load input also transfers the input registers into the DAC registers. When it is low at the strobe, it suppresses software power-down commands in that word.

Top module: `qdac_pwr_ctrl`

## Requirements
- R1: After reset, all four channels are powered, the internal reference is on and selected, the bias is on, every DAC register reads 0 and busy is low.
- R2: Command 0000 writes the input register only. Command 0001 copies the input register into the DAC register. Command 0011 does both in the same cycle. Address values 0 to 3 pick one channel, 1111 picks all four, and any other address picks none. Channel n's DAC code sits at bits 16n+15 to 16n of the dac_codes output.
- R3: Command 0100 powers down the addressed channels. Its data field leaves every input and DAC register unchanged.
- R4: Command 0101 turns off all channels, the internal reference and the bias in one step.
- R5: Command 0110 selects the internal reference and turns it on. Command 0111 selects the external reference and turns the internal one off.
- R6: A reference turned off by 0111 returns only through 0110. A reference turned off by 0101 also returns with any event that powers up a channel.
- R7: A channel powered up from the off state starts the busy flag. Busy stays high for SHORT_US microseconds of clock cycles (600 at default settings) when the bias was on. It stays high for LONG_US microseconds (700) when the bias was off.
- R8: While chip-select is high and the synchronized load input is low, every DAC register takes its input register value on every cycle.
- R9: A falling edge on the load input powers up all channels whatever the chip-select level. With chip-select low and no strobe, it changes no DAC register.
- R10: If the synchronized load input is low at a strobe, the command executes and then all DAC registers load from the input registers. Commands 0100, 0101 and 0111 have no effect in that case.
- R11: The load input passes through a two-flop synchronizer, so a change is acted on at the third rising clock edge after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_valid | input | 1 | One-cycle strobe at chip-select rising edge |
| cmd_code | input | 4 | Command field |
| cmd_addr | input | 4 | Channel address field |
| cmd_data | input | 16 | Data field |
| cs_level | input | 1 | Current chip-select level (1 = high) |
| ldac_n | input | 1 | Asynchronous active-low load input |
| dac_codes | output | 64 | Four DAC registers, channel n at bits 16n+15:16n |
| ch_pwr | output | 4 | Per-channel power state (1 = on) |
| ref_on | output | 1 | Internal reference on |
| ref_ext | output | 1 | External reference selected |
| bias_on | output | 1 | Bias circuit on |
| busy | output | 1 | Power-up settling in progress |

## Verification
Results of a strobed command appear at the first rising edge after the strobe. A load-input change acts at the third edge, because it passes the two synchronizer flops first. Busy rises at the same edge as the channel it covers and falls exactly 600 or 700 cycles later. The bench drives all inputs on the falling clock edge and advances a cycle-accurate model by one step for each cycle. It then compares every output on the next falling edge, so each result is checked in the cycle it is due.

// File: rtl/qdac_pkg.sv
package qdac_pkg;

    localparam int NCH = 4;
    localparam int DW  = 16;

    typedef enum logic [3:0] {
        CMD_WR_IN   = 4'b0000,
        CMD_UPD     = 4'b0001,
        CMD_WR_UPD  = 4'b0011,
        CMD_PD_CH   = 4'b0100,
        CMD_PD_CHIP = 4'b0101,
        CMD_REF_INT = 4'b0110,
        CMD_REF_EXT = 4'b0111
    } cmd_e;

    // Internal reference state: on, or off together with the reason it went off
    typedef enum logic [1:0] {
        REF_ON       = 2'd0,
        REF_OFF_EXT  = 2'd1,
        REF_OFF_CHIP = 2'd2
    } ref_st_e;

    typedef struct packed {
        logic [NCH-1:0] wr;
        logic [NCH-1:0] upd;
        logic [NCH-1:0] pd;
        logic           chip_pd;
        logic           sel_int;
        logic           sel_ext;
    } dec_t;

    function automatic logic [NCH-1:0] chan_sel(input logic [3:0] a);
        logic [NCH-1:0] s;
        for (int i = 0; i < NCH; i++) s[i] = (a == 4'(i)) || (a == 4'hF);
        return s;
    endfunction

endpackage

// File: rtl/qdac_ldac_sync.sv
module qdac_ldac_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic ldac_n,
    output logic ldac_low,
    output logic ldac_fall
);
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk) begin
        if (rst) sh_q <= '1;
        else     sh_q <= {sh_q[STAGES-1:0], ldac_n};
    end

    assign ldac_low  = ~sh_q[STAGES-1];
    assign ldac_fall = sh_q[STAGES] & ~sh_q[STAGES-1];
endmodule

// File: rtl/qdac_settle_timer.sv
module qdac_settle_timer #(
    parameter int SHORT_CYC = 600,
    parameter int LONG_CYC  = 700
) (
    input  logic clk,
    input  logic rst,
    input  logic start,
    input  logic long_sel,
    output logic busy
);
    localparam int MAXC = (LONG_CYC > SHORT_CYC) ? LONG_CYC : SHORT_CYC;
    localparam int CW   = $clog2(MAXC + 1);

    logic [CW-1:0] cnt_q;

    always_ff @(posedge clk) begin
        if (rst)                cnt_q <= '0;
        else if (start)         cnt_q <= long_sel ? CW'(LONG_CYC) : CW'(SHORT_CYC);
        else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
    end

    assign busy = (cnt_q != '0);
endmodule

// File: rtl/qdac_chan_regs.sv
module qdac_chan_regs
    import qdac_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NCH-1:0]    wr_mask,
    input  logic [NCH-1:0]    upd_mask,
    input  logic [DW-1:0]     wr_data,
    output logic [NCH*DW-1:0] dac_flat
);
    for (genvar g = 0; g < NCH; g++) begin : g_ch
        logic [DW-1:0] in_q, dac_q, in_nxt;

        assign in_nxt = wr_mask[g] ? wr_data : in_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                in_q  <= '0;
                dac_q <= '0;
            end else begin
                in_q <= in_nxt;
                if (upd_mask[g]) dac_q <= in_nxt;
            end
        end

        assign dac_flat[g*DW +: DW] = dac_q;
    end
endmodule

// File: rtl/qdac_pwr_ctrl.sv
module qdac_pwr_ctrl
    import qdac_pkg::*;
#(
    parameter int CLK_HZ   = 50_000_000,
    parameter int SHORT_US = 12,
    parameter int LONG_US  = 14
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          cmd_valid,
    input  logic [3:0]    cmd_code,
    input  logic [3:0]    cmd_addr,
    input  logic [15:0]   cmd_data,
    input  logic          cs_level,
    input  logic          ldac_n,
    output logic [63:0]   dac_codes,
    output logic [3:0]    ch_pwr,
    output logic          ref_on,
    output logic          ref_ext,
    output logic          bias_on,
    output logic          busy
);
    localparam int CYC_PER_US = CLK_HZ / 1_000_000;
    localparam int SHORT_CYC  = CYC_PER_US * SHORT_US;
    localparam int LONG_CYC   = CYC_PER_US * LONG_US;

    logic ldac_low, ldac_fall;

    qdac_ldac_sync #(.STAGES(2)) i_sync (
        .clk(clk), .rst(rst), .ldac_n(ldac_n),
        .ldac_low(ldac_low), .ldac_fall(ldac_fall)
    );

    // Command decode; power-down style commands are blocked while load is low
    dec_t           dec;
    logic [NCH-1:0] amask;
    logic           pd_ok, load_all;

    assign amask    = chan_sel(cmd_addr);
    assign pd_ok    = cmd_valid && !ldac_low;
    assign load_all = ldac_low && (cs_level || cmd_valid);

    always_comb begin
        dec = '0;
        if (cmd_valid) begin
            unique case (cmd_code)
                CMD_WR_IN:   dec.wr = amask;
                CMD_UPD:     dec.upd = amask;
                CMD_WR_UPD:  begin dec.wr = amask; dec.upd = amask; end
                CMD_PD_CH:   dec.pd = pd_ok ? amask : '0;
                CMD_PD_CHIP: begin
                    dec.pd      = pd_ok ? '1 : '0;
                    dec.chip_pd = pd_ok;
                end
                CMD_REF_INT: dec.sel_int = 1'b1;
                CMD_REF_EXT: dec.sel_ext = pd_ok;
                default:     dec = '0;
            endcase
        end
    end

    logic [NCH-1:0] upd_eff, pu_mask;
    assign upd_eff = dec.upd | {NCH{load_all}};
    assign pu_mask = upd_eff | {NCH{ldac_fall}};

    qdac_chan_regs i_regs (
        .clk(clk), .rst(rst),
        .wr_mask(dec.wr), .upd_mask(upd_eff),
        .wr_data(cmd_data), .dac_flat(dac_codes)
    );

    // Power state
    logic [NCH-1:0] ch_q;
    ref_st_e        ref_q;
    logic           ext_q, bias_q;
    logic           any_pu, t_start;

    assign any_pu  = |pu_mask;
    assign t_start = |(pu_mask & ~ch_q);

    always_ff @(posedge clk) begin
        if (rst) begin
            ch_q   <= '1;
            ref_q  <= REF_ON;
            ext_q  <= 1'b0;
            bias_q <= 1'b1;
        end else begin
            ch_q <= (ch_q | pu_mask) & ~dec.pd;

            if (dec.chip_pd)                bias_q <= 1'b0;
            else if (any_pu || dec.sel_int) bias_q <= 1'b1;

            if (dec.sel_int) begin
                ref_q <= REF_ON;
                ext_q <= 1'b0;
            end else if (dec.sel_ext) begin
                ref_q <= REF_OFF_EXT;
                ext_q <= 1'b1;
            end else if (dec.chip_pd) begin
                if (ref_q == REF_ON) ref_q <= REF_OFF_CHIP;
            end else if (any_pu && ref_q == REF_OFF_CHIP) begin
                ref_q <= REF_ON;
            end
        end
    end

    qdac_settle_timer #(.SHORT_CYC(SHORT_CYC), .LONG_CYC(LONG_CYC)) i_timer (
        .clk(clk), .rst(rst), .start(t_start), .long_sel(!bias_q), .busy(busy)
    );

    assign ch_pwr  = ch_q;
    assign ref_on  = (ref_q == REF_ON);
    assign ref_ext = ext_q;
    assign bias_on = bias_q;
endmodule

// File: rtl/qdac_pwr_chk.sv
module qdac_pwr_chk (
    input logic       clk,
    input logic       rst,
    input logic       cmd_valid,
    input logic [3:0] cmd_code,
    input logic [3:0] ch_pwr,
    input logic       ref_on,
    input logic       ref_ext,
    input logic       bias_on,
    input logic       busy
);
    AST_BIAS_OFF_ALL_OFF: assert property (@(posedge clk) disable iff (rst)
        !bias_on |-> (ch_pwr == 4'b0000) && !ref_on); // R4

    AST_EXT_REF_OFF: assert property (@(posedge clk) disable iff (rst)
        ref_ext |-> !ref_on); // R5

    AST_EXT_STICKY: assert property (@(posedge clk) disable iff (rst)
        (ref_ext && !(cmd_valid && cmd_code == 4'b0110)) |=> ref_ext); // R6

    AST_BUSY_ON_POWER_UP: assert property (@(posedge clk) disable iff (rst)
        ((ch_pwr & ~$past(ch_pwr)) != 4'b0000) |-> busy); // R7

    AST_BUSY_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(busy) |-> ((ch_pwr & ~$past(ch_pwr)) != 4'b0000)); // R7
endmodule

bind qdac_pwr_ctrl qdac_pwr_chk i_chk (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
    .ch_pwr(ch_pwr), .ref_on(ref_on), .ref_ext(ref_ext),
    .bias_on(bias_on), .busy(busy)
);

// File: tb/test_qdac_pwr_ctrl.sv
module test_qdac_pwr_ctrl;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = '0;
    logic [3:0]  cmd_addr = '0;
    logic [15:0] cmd_data = '0;
    logic        cs_level = 1'b1;
    logic        ldac_n = 1'b1;
    logic [63:0] dac_codes;
    logic [3:0]  ch_pwr;
    logic        ref_on, ref_ext, bias_on, busy;

    int checks = 0;
    int failures = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    qdac_pwr_ctrl i_qdac_pwr_ctrl (
        .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .cmd_addr(cmd_addr), .cmd_data(cmd_data), .cs_level(cs_level),
        .ldac_n(ldac_n), .dac_codes(dac_codes), .ch_pwr(ch_pwr),
        .ref_on(ref_on), .ref_ext(ref_ext), .bias_on(bias_on), .busy(busy)
    );

    // Behavioural model, built from the requirements
    logic [15:0] m_in [4];
    logic [15:0] m_dac [4];
    logic [3:0]  m_on;
    int          m_ref;      // 0 on, 1 off by external select, 2 off by chip power-down
    bit          m_ext, m_bias;
    int          m_cnt;
    bit          m_s1, m_s2, m_s3;

    function automatic logic [3:0] sel_of(input logic [3:0] a);
        if (a == 4'hF) return 4'hF;
        if (a < 4)     return 4'(1 << a);
        return 4'h0;
    endfunction

    task automatic model_reset();
        for (int i = 0; i < 4; i++) begin m_in[i] = '0; m_dac[i] = '0; end
        m_on = 4'hF; m_ref = 0; m_ext = 0; m_bias = 1; m_cnt = 0;
        m_s1 = 1; m_s2 = 1; m_s3 = 1;
    endtask

    task automatic model_step(input bit v, input logic [3:0] c, input logic [3:0] a,
                              input logic [15:0] d, input bit cs, input bit ldn);
        bit low, fall, pdok, loadall, chippd;
        logic [3:0] sel, upd, pu, pd;
        low  = !m_s2;
        fall = m_s3 && !m_s2;
        sel  = sel_of(a);
        pdok = v && !low;
        loadall = low && (cs || v);
        upd = '0; pd = '0; chippd = 0;
        if (v && (c == 4'd0 || c == 4'd3))
            for (int i = 0; i < 4; i++) if (sel[i]) m_in[i] = d;
        if (v && (c == 4'd1 || c == 4'd3)) upd = sel;
        if (loadall) upd = 4'hF;
        for (int i = 0; i < 4; i++) if (upd[i]) m_dac[i] = m_in[i];
        if (pdok && c == 4'd4) pd = sel;
        if (pdok && c == 4'd5) begin pd = 4'hF; chippd = 1; end
        pu = upd | (fall ? 4'hF : 4'h0);
        if ((pu & ~m_on) != 0) m_cnt = m_bias ? 600 : 700;
        else if (m_cnt > 0) m_cnt--;
        m_on = (m_on | pu) & ~pd;
        if (v && c == 4'd6) begin m_ref = 0; m_ext = 0; end
        else if (pdok && c == 4'd7) begin m_ref = 1; m_ext = 1; end
        else if (chippd) begin if (m_ref == 0) m_ref = 2; end
        else if (pu != 0 && m_ref == 2) m_ref = 0;
        if (chippd) m_bias = 0;
        else if (pu != 0 || (v && c == 4'd6)) m_bias = 1;
        m_s3 = m_s2; m_s2 = m_s1; m_s1 = ldn;
    endtask

    task automatic compare(input string tag);
        logic [63:0] ed;
        ed = {m_dac[3], m_dac[2], m_dac[1], m_dac[0]};
        checks++;
        if (dac_codes !== ed || ch_pwr !== m_on || ref_on !== (m_ref == 0) ||
            ref_ext !== m_ext || bias_on !== m_bias || busy !== (m_cnt != 0)) begin
            failures++;
            $display("FAIL %s: dac=%h/%h pwr=%b/%b ref_on=%b/%b ext=%b/%b bias=%b/%b busy=%b/%b",
                     tag, dac_codes, ed, ch_pwr, m_on, ref_on, (m_ref == 0), ref_ext, m_ext,
                     bias_on, m_bias, busy, (m_cnt != 0));
        end
    endtask

    // One clock cycle: drive at a falling edge, compare at the next falling edge
    task automatic cyc(input bit v, input logic [3:0] c, input logic [3:0] a,
                       input logic [15:0] d, input bit cs, input bit ldn, input string tag);
        cmd_valid = v; cmd_code = c; cmd_addr = a; cmd_data = d;
        cs_level = cs; ldac_n = ldn;
        model_step(v, c, a, d, cs, ldn);
        @(negedge clk);
        compare(tag);
    endtask

    task automatic cmd(input logic [3:0] c, input logic [3:0] a, input logic [15:0] d,
                       input string tag);
        cyc(1, c, a, d, 1, 1, tag);
    endtask

    task automatic idle(input int n, input string tag);
        for (int i = 0; i < n; i++) cyc(0, 0, 0, 0, 1, 1, tag);
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            failures++;
            $display("FAIL watchdog: run did not finish");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst = 1'b0;
        compare("R1 reset state");

        // R2 write, update, write+update, bad address
        cmd(4'd0, 4'd0, 16'h1234, "R2 write input only");
        cmd(4'd1, 4'd0, 16'h0000, "R2 update from input");
        cmd(4'd3, 4'hF, 16'hABCD, "R2 write+update all");
        cmd(4'd3, 4'd5, 16'h5A5A, "R2 unused address");

        // R3 power-down one channel, data ignored; R7 short settle
        cmd(4'd4, 4'd2, 16'hFFFF, "R3 power-down ch2");
        cmd(4'd1, 4'd2, 16'h0000, "R7 update powers ch2");
        idle(598, "R7 short busy");
        idle(4, "R7 short busy end");

        // R4 full chip down; R7 long settle
        cmd(4'd5, 4'd0, 16'h1111, "R4 chip power-down");
        cmd(4'd3, 4'd0, 16'h2222, "R7 long power-up");
        idle(698, "R7 long busy");
        idle(4, "R7 long busy end");

        // R5 and R6 reference rules
        cmd(4'd7, 4'd0, 16'h0, "R5 select external");
        cmd(4'd5, 4'd0, 16'h0, "R6 chip down after external");
        cmd(4'd3, 4'hF, 16'h3333, "R6 external ref stays off");
        cmd(4'd6, 4'd0, 16'h0, "R5 select internal");
        cmd(4'd5, 4'd0, 16'h0, "R6 chip down");
        idle(2, "R6 settle");
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R9 R6 load fall restores ref");
        idle(705, "R9 busy");

        // R8 and R11: cs high, load low copies inputs at the third edge
        cmd(4'd0, 4'd1, 16'h5555, "R8 stage input");
        cyc(0, 0, 0, 0, 1, 0, "R11 edge 1 no change");
        cyc(0, 0, 0, 0, 1, 0, "R11 edge 2 no change");
        cyc(0, 0, 0, 0, 1, 0, "R11 R8 edge 3 load");
        cyc(0, 0, 0, 0, 1, 0, "R8 load held");
        idle(4, "R8 release");

        // R9: cs low, load pulse powers all, no update
        cmd(4'd4, 4'hF, 16'h0, "R3 power-down all channels");
        cmd(4'd0, 4'd0, 16'h9999, "R9 stage input");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 0, "R9 load pulse cs low");
        for (int i = 0; i < 3; i++) cyc(0, 0, 0, 0, 0, 1, "R9 no update");
        idle(605, "R9 busy");

        // R10: load low at strobe suppresses power-down and updates all
        for (int i = 0; i < 4; i++) cyc(0, 0, 0, 0, 0, 0, "R10 hold load low");
        cyc(1, 4'd4, 4'd0, 16'h0, 0, 0, "R10 power-down suppressed");
        cyc(1, 4'd7, 4'd0, 16'h0, 0, 0, "R10 external select suppressed");
        cyc(1, 4'd5, 4'd0, 16'h0, 0, 0, "R10 chip power-down suppressed");
        cyc(1, 4'd0, 4'd3, 16'h7777, 0, 0, "R10 write then load all");
        idle(6, "R10 release");

        // Mixed random stimulus
        begin
            int seed;
            seed = 7;
            void'($urandom(seed));
            for (int i = 0; i < 3000; i++) begin
                bit v, cs, ldn;
                logic [3:0] c, a;
                logic [15:0] d;
                v   = ($urandom % 4) == 0;
                c   = 4'($urandom % 8);
                a   = (($urandom % 3) == 0) ? 4'hF : 4'($urandom % 6);
                d   = 16'($urandom);
                cs  = ($urandom % 2) == 0;
                ldn = ($urandom % 8) != 0;
                cyc(v, c, a, d, cs, ldn, "mixed R2 R10");
            end
        end
        idle(710, "mixed tail");

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule